// File: doc/BRIEF.md
# SPI NOR Flash Range Erase Sequencer

This block erases a byte range of a serial NOR flash without processor help. A request arrives as a start address, a byte count, a small-block select and a one-cycle `go` strobe. The block first validates the range. If the count covers the whole device it sends one chip-erase command. Otherwise it walks the range one erase block at a time. Before every erase it polls the flash status register until the write-in-progress bit clears. It then sends a write-enable command in a separate chip-select frame, followed by the erase command.

The block drives a byte-level SPI master. It holds an active-low chip select and offers one byte at a time on `txByte`/`txValid`; the byte is taken when `txReady` is high. The master returns the byte clocked in from the flash on `rxByte` with a one-cycle `rxValid`. The sequencer waits for that reply before it offers the next byte. At the end the block pulses `done` together with a result code. On failure it also gives the address of the block it was working on. A ready poll that lasts too long aborts the run; the limit is a cycle-count parameter.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose start address plus length exceeds `DEV_BYTES` finishes with `errCode` = 1 (range), `errAddr` equal to the start address, and no SPI frame at all.
- R2: A request whose length is not a whole multiple of the active block size finishes with `errCode` = 1 and no SPI frame.
- R3: When the length equals `DEV_BYTES`, exactly one erase frame is sent. It has the single byte 0xC7 and no address bytes.
- R4: Otherwise, length/block erase frames are sent. Frame k carries the address start + k*block as 3 bytes, most significant first, after the opcode in the same frame.
- R5: With `useSmallBlk` = 1 the block erase opcode is 0x20 and the block is 4096 bytes. With `useSmallBlk` = 0 the opcode is 0xD8 and the block is `SECTOR_BYTES`.
- R6: Before each erase, the status register is read with a frame of 0x05 followed by a dummy 0x00. The read is repeated until bit 0 of the returned byte is 0.
- R7: A frame holding only 0x06 is sent directly before every erase frame, after the last status read.
- R8: If a ready poll lasts `TIMEOUT_CYCLES` cycles without bit 0 reading 0, the run ends with `errCode` = 2 and `errAddr` equal to the address of the block being waited on, and no further erase is sent. A ready reply that arrives in the expiring cycle counts as ready.
- R9: `csN` is high for at least one cycle between frames. `txValid` is asserted only while `csN` is low, and `txByte` is held until the byte is taken.
- R10: A zero length finishes with `errCode` = 0 and no SPI frame.
- R11: `done` is a one-cycle pulse and `busy` is high from `go` until `done`. A `go` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe, one cycle |
| startAddr | input | 24 | First byte address of the range |
| lenBytes | input | LEN_W | Byte count of the range |
| useSmallBlk | input | 1 | 1 selects 4096-byte blocks (0x20), 0 selects sectors (0xD8) |
| csN | output | 1 | Active-low flash chip select |
| txByte | output | 8 | Byte to send |
| txValid | output | 1 | `txByte` is offered |
| txReady | input | 1 | Master takes the offered byte |
| rxByte | input | 8 | Byte received for the last byte sent |
| rxValid | input | 1 | `rxByte` is valid, one cycle |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Completion pulse |
| errCode | output | 2 | 0 ok, 1 range, 2 ready timeout; valid with `done` |
| errAddr | output | 24 | Failing address; valid with `done` when `errCode` is not 0 |

## Verification
Two events can fall in the same cycle: the ready-poll timer reaching its limit, and a status reply arriving. When they coincide, the reply decides. The bench sets a flash busy period of 0 to 40 status reads and sweeps it across the limit. Each run is judged to be either a full, correctly gated erase or a timeout at the first block with no erase sent, and the outcome must switch from success to timeout only once across the sweep. Separately, the flash can be made to stay busy after the k-th erase. This checks that the abort reports block k and that nothing follows it.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int ADDR_W = 24;
  localparam int SMALL_BLK_BYTES = 4096;

  localparam logic [7:0] OP_STATUS    = 8'h05;
  localparam logic [7:0] OP_WREN      = 8'h06;
  localparam logic [7:0] OP_CHIP      = 8'hC7;
  localparam logic [7:0] OP_BLK_SMALL = 8'h20;
  localparam logic [7:0] OP_BLK_LARGE = 8'hD8;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_RANGE   = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_POLL_CMD, S_POLL_DAT, S_G_REPOLL,
    S_G_WREN, S_WREN, S_G_ERASE, S_ERASE, S_G_NEXT, S_FIN
  } seqState_e;

  typedef struct packed {
    logic loadReq;
    logic advBlk;
    logic clrTimer;
    logic incTimer;
    logic clrIdx;
    logic incIdx;
  } dpCtl_t;
endpackage

// File: rtl/flash_erase_dp.sv
module flash_erase_dp
  import flash_erase_pkg::*;
#(
  parameter int DEV_BYTES      = 1 << 20,
  parameter int SECTOR_BYTES   = 65536,
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int LEN_W          = $clog2(DEV_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  lenBytes,
  input  logic              useSmallBlk,
  output logic [ADDR_W-1:0] curAddr,
  output logic              rangeBad,
  output logic              lenZero,
  output logic              isChip,
  output logic              lastBlk,
  output logic              smallSel,
  output logic              timerExpired,
  output logic [1:0]        idx,
  output logic [7:0]        addrByte
);
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int SUM_W = ((LEN_W > ADDR_W) ? LEN_W : ADDR_W) + 1;

  logic [LEN_W-1:0] remLen;
  logic [LEN_W-1:0] blkSize;
  logic [SUM_W-1:0] endSum;
  logic [TMR_W-1:0] timer;

  assign blkSize = smallSel ? LEN_W'(SMALL_BLK_BYTES) : LEN_W'(SECTOR_BYTES);
  assign endSum  = SUM_W'(curAddr) + SUM_W'(remLen);
  assign rangeBad = (endSum > SUM_W'(DEV_BYTES)) || (|(remLen & (blkSize - 1'b1)));
  assign lenZero  = (remLen == '0);
  assign isChip   = (remLen == LEN_W'(DEV_BYTES));
  assign lastBlk  = (remLen == blkSize);
  assign timerExpired = (timer == TMR_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remLen   <= '0;
      smallSel <= 1'b0;
    end else if (ctl.loadReq) begin
      curAddr  <= startAddr;
      remLen   <= lenBytes;
      smallSel <= useSmallBlk;
    end else if (ctl.advBlk) begin
      curAddr  <= curAddr + ADDR_W'(blkSize);
      remLen   <= remLen - blkSize;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             timer <= '0;
    else if (ctl.clrTimer)                 timer <= '0;
    else if (ctl.incTimer && !timerExpired) timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           idx <= '0;
    else if (ctl.clrIdx) idx <= '0;
    else if (ctl.incIdx) idx <= idx + 1'b1;
  end

  always_comb begin
    case (idx)
      2'd1:    addrByte = curAddr[23:16];
      2'd2:    addrByte = curAddr[15:8];
      default: addrByte = curAddr[7:0];
    endcase
  end
endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
  import flash_erase_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic              rxBusyBit,
  input  logic              rangeBad,
  input  logic              lenZero,
  input  logic              isChip,
  input  logic              lastBlk,
  input  logic              smallSel,
  input  logic              timerExpired,
  input  logic [1:0]        idx,
  input  logic [7:0]        addrByte,
  input  logic [ADDR_W-1:0] curAddr,
  output dpCtl_t            ctl,
  output logic              csN,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic              busy,
  output logic              done,
  output logic [1:0]        errCode,
  output logic [ADDR_W-1:0] errAddr
);
  seqState_e state, nextState;
  logic waitRx, sendState, pollState, byteDone, readyNow, abortNow;
  logic [1:0] lastIdx;

  assign sendState = (state == S_POLL_CMD) || (state == S_POLL_DAT) ||
                     (state == S_WREN) || (state == S_ERASE);
  assign pollState = (state == S_POLL_CMD) || (state == S_POLL_DAT) || (state == S_G_REPOLL);
  assign byteDone  = sendState && waitRx && rxValid;
  assign readyNow  = (state == S_POLL_DAT) && byteDone && !rxBusyBit;
  assign abortNow  = pollState && timerExpired && !readyNow;
  assign txValid   = sendState && !waitRx && !abortNow;
  assign csN       = !sendState;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign lastIdx   = isChip ? 2'd0 : 2'd3;

  always_comb begin
    ctl       = '0;
    nextState = state;
    txByte    = 8'h00;
    case (state)
      S_IDLE: if (go) begin ctl.loadReq = 1'b1; nextState = S_CHECK; end
      S_CHECK: begin
        if (rangeBad || lenZero) nextState = S_FIN;
        else begin ctl.clrTimer = 1'b1; nextState = S_POLL_CMD; end
      end
      S_POLL_CMD: begin
        ctl.incTimer = 1'b1;
        txByte = OP_STATUS;
        if (byteDone) nextState = S_POLL_DAT;
      end
      S_POLL_DAT: begin
        ctl.incTimer = 1'b1;
        if (byteDone) nextState = rxBusyBit ? S_G_REPOLL : S_G_WREN;
      end
      S_G_REPOLL: begin ctl.incTimer = 1'b1; nextState = S_POLL_CMD; end
      S_G_WREN:   nextState = S_WREN;
      S_WREN: begin
        txByte = OP_WREN;
        if (byteDone) nextState = S_G_ERASE;
      end
      S_G_ERASE: begin ctl.clrIdx = 1'b1; nextState = S_ERASE; end
      S_ERASE: begin
        if (idx != 2'd0)  txByte = addrByte;
        else if (isChip)  txByte = OP_CHIP;
        else              txByte = smallSel ? OP_BLK_SMALL : OP_BLK_LARGE;
        if (byteDone) begin
          if (idx != lastIdx)          ctl.incIdx = 1'b1;
          else if (isChip || lastBlk)  nextState = S_FIN;
          else begin ctl.advBlk = 1'b1; nextState = S_G_NEXT; end
        end
      end
      S_G_NEXT: begin ctl.clrTimer = 1'b1; nextState = S_POLL_CMD; end
      S_FIN:    nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
    if (abortNow) nextState = S_FIN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitRx  <= 1'b0;
      errCode <= ERR_NONE;
      errAddr <= '0;
    end else begin
      state <= nextState;
      if (txValid && txReady)               waitRx <= 1'b1;
      else if (byteDone || nextState == S_FIN) waitRx <= 1'b0;
      if (state == S_IDLE && go) errCode <= ERR_NONE;
      if (state == S_CHECK && rangeBad) begin
        errCode <= ERR_RANGE;
        errAddr <= curAddr;
      end
      if (abortNow) begin
        errCode <= ERR_TIMEOUT;
        errAddr <= curAddr;
      end
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int DEV_BYTES      = 1 << 20,
  parameter int SECTOR_BYTES   = 65536,
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int LEN_W          = $clog2(DEV_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic [23:0]       startAddr,
  input  logic [LEN_W-1:0]  lenBytes,
  input  logic              useSmallBlk,
  output logic              csN,
  output logic [7:0]        txByte,
  output logic              txValid,
  input  logic              txReady,
  input  logic [7:0]        rxByte,
  input  logic              rxValid,
  output logic              busy,
  output logic              done,
  output logic [1:0]        errCode,
  output logic [23:0]       errAddr
);
  dpCtl_t ctl;
  logic [ADDR_W-1:0] curAddr;
  logic rangeBad, lenZero, isChip, lastBlk, smallSel, timerExpired;
  logic [1:0] idx;
  logic [7:0] addrByte;
  logic unusedRxBits;

  assign unusedRxBits = ^rxByte[7:1];

  flash_erase_dp #(
    .DEV_BYTES(DEV_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .LEN_W(LEN_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr), .lenBytes(lenBytes),
    .useSmallBlk(useSmallBlk), .curAddr(curAddr), .rangeBad(rangeBad), .lenZero(lenZero),
    .isChip(isChip), .lastBlk(lastBlk), .smallSel(smallSel), .timerExpired(timerExpired),
    .idx(idx), .addrByte(addrByte)
  );

  flash_erase_ctl i_ctl (
    .clk(clk), .rstN(rstN), .go(go), .txReady(txReady), .rxValid(rxValid),
    .rxBusyBit(rxByte[0]), .rangeBad(rangeBad), .lenZero(lenZero), .isChip(isChip),
    .lastBlk(lastBlk), .smallSel(smallSel), .timerExpired(timerExpired), .idx(idx),
    .addrByte(addrByte), .curAddr(curAddr), .ctl(ctl), .csN(csN), .txValid(txValid),
    .txByte(txByte), .busy(busy), .done(done), .errCode(errCode), .errAddr(errAddr)
  );
endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic [7:0] txByte,
  input logic       txValid,
  input logic       txReady,
  input logic       busy,
  input logic       done,
  input logic [1:0] errCode
);
  logic [2:0] byteCnt;
  logic [7:0] frameOp;
  logic       eraseFirst;

  assign eraseFirst = txValid && txReady && (byteCnt == 3'd0) &&
                      ((txByte == 8'hC7) || (txByte == 8'h20) || (txByte == 8'hD8));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
      frameOp <= '0;
    end else if (csN) begin
      byteCnt <= '0;
    end else if (txValid && txReady) begin
      if (byteCnt != 3'd7) byteCnt <= byteCnt + 1'b1;
      if (byteCnt == 3'd0) frameOp <= txByte;
    end
  end

  // R9: bytes are offered only inside a frame
  a_r9_tx_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !csN);

  // R9: an offered byte stays put until taken (or the run ends)
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> ((txValid && $stable(txByte)) || done));

  // R7: every erase frame follows a write-enable frame
  a_r7_wren_before_erase: assert property (@(posedge clk) disable iff (!rstN)
    eraseFirst |-> (frameOp == 8'h06));

  // R11: completion pulse is one cycle with the bus idle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !txValid));

  // R11: no frame while not busy
  a_r11_idle_no_cs: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  // R8: result codes stay within the defined set
  a_r8_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (errCode != 2'b11));
endmodule

bind flash_erase_seq flash_erase_chk i_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .txByte(txByte), .txValid(txValid),
  .txReady(txReady), .busy(busy), .done(done), .errCode(errCode)
);

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/1ps
module test_flash_erase_seq;
  localparam int DEV   = 32768;
  localparam int SECT  = 16384;
  localparam int TMO   = 200;
  localparam int LW    = $clog2(DEV + 1);
  localparam int LOGN  = 16;

  logic clk = 1'b0, rstN = 1'b0, go = 1'b0, useSmallBlk = 1'b0;
  logic [23:0] startAddr = '0;
  logic [LW-1:0] lenBytes = '0;
  logic csN, txValid, busy, done;
  logic [7:0] txByte;
  logic txReady = 1'b0, rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic [1:0] errCode;
  logic [23:0] errAddr;

  always #2.5 clk = ~clk;

  flash_erase_seq #(.DEV_BYTES(DEV), .SECTOR_BYTES(SECT), .TIMEOUT_CYCLES(TMO)) i_flash_erase_seq (
    .clk(clk), .rstN(rstN), .go(go), .startAddr(startAddr), .lenBytes(lenBytes),
    .useSmallBlk(useSmallBlk), .csN(csN), .txByte(txByte), .txValid(txValid),
    .txReady(txReady), .rxByte(rxByte), .rxValid(rxValid), .busy(busy), .done(done),
    .errCode(errCode), .errAddr(errAddr)
  );

  // ---------------- SPI master + flash model ----------------
  logic clrLog = 1'b0;
  int   busyInit = 0, busyAfter = 3, stuckAt = -1;
  logic [1:0] stall = '0;
  logic p0V = 1'b0; logic [7:0] p0B = '0;
  logic [7:0] fBytes [0:7];
  int   fCnt = 0, busyLeft = 0, eCnt = 0, fTotal = 0;
  logic lastStat = 1'b1, pollReady = 1'b0, wel = 1'b0, lastWren = 1'b0;
  logic [7:0]  eOp  [0:LOGN-1];
  logic [23:0] eAdr [0:LOGN-1];
  int          eLen [0:LOGN-1];
  logic        eOk  [0:LOGN-1];
  logic wip;

  assign wip = (busyLeft != 0) || (stuckAt >= 0 && eCnt >= stuckAt);

  always @(posedge clk) begin
    stall   <= stall + 1'b1;
    txReady <= (stall != 2'd2);
    rxValid <= p0V;
    rxByte  <= p0B;
    p0V     <= txValid && txReady;
    p0B     <= 8'hFF;
    if (clrLog) begin
      eCnt <= 0; fTotal <= 0; busyLeft <= busyInit; fCnt <= 0;
      pollReady <= 1'b0; wel <= 1'b0; lastWren <= 1'b0;
    end else if (csN) begin
      if (fCnt != 0) begin
        fTotal   <= fTotal + 1;
        lastWren <= (fBytes[0] == 8'h06) && (fCnt == 1);
        if (fBytes[0] == 8'h05) pollReady <= (fCnt >= 2) && !lastStat;
        if (fBytes[0] == 8'h06) wel <= (fCnt == 1);
        if (fBytes[0] == 8'hC7 || fBytes[0] == 8'h20 || fBytes[0] == 8'hD8) begin
          if (eCnt < LOGN) begin
            eOp[eCnt]  <= fBytes[0];
            eAdr[eCnt] <= {fBytes[1], fBytes[2], fBytes[3]};
            eLen[eCnt] <= fCnt;
            eOk[eCnt]  <= wel && pollReady && lastWren;
          end
          eCnt <= eCnt + 1; wel <= 1'b0; pollReady <= 1'b0; busyLeft <= busyAfter;
        end
      end
      fCnt <= 0;
    end else if (txValid && txReady) begin
      if (fCnt < 8) fBytes[fCnt] <= txByte;
      fCnt <= fCnt + 1;
      if (fCnt == 1 && fBytes[0] == 8'h05) begin
        p0B      <= {7'b0, wip};
        lastStat <= wip;
        if (busyLeft != 0) busyLeft <= busyLeft - 1;
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [1:0] gotCode; logic [23:0] gotAddr;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runErase(input int st, input int ln, input bit sm, input int preBusy,
                          input int stuck, input bit extraGo);
    @(negedge clk);
    startAddr = st[23:0]; lenBytes = ln[LW-1:0]; useSmallBlk = sm;
    busyInit = preBusy; stuckAt = stuck; clrLog = 1'b1;
    @(negedge clk); clrLog = 1'b0; go = 1'b1;
    @(negedge clk); go = 1'b0;
    if (extraGo) begin
      repeat (15) @(negedge clk);
      startAddr = 24'h000100; lenBytes = LW'(4096); useSmallBlk = ~sm; go = 1'b1;
      @(negedge clk); go = 1'b0; startAddr = st[23:0]; lenBytes = ln[LW-1:0]; useSmallBlk = sm;
    end
    while (!done) @(negedge clk);
    gotCode = errCode; gotAddr = errAddr;
    @(negedge clk);
    chk(!done, "R11", "done width", done, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic checkNormal(input int st, input int ln, input bit sm, input string tag);
    int blk, n; bit bad;
    blk = sm ? 4096 : SECT;
    bad = (st + ln > DEV) || (ln % blk != 0);
    if (bad) begin
      chk(gotCode == 2'd1, (st + ln > DEV) ? "R1" : "R2", {tag, " code"}, gotCode, 1);
      chk(gotAddr == st[23:0], "R1", {tag, " addr"}, gotAddr, st);
      chk(fTotal == 0, "R2", {tag, " no frames"}, fTotal, 0);
    end else if (ln == 0) begin
      chk(gotCode == 2'd0, "R10", {tag, " code"}, gotCode, 0);
      chk(fTotal == 0, "R10", {tag, " no frames"}, fTotal, 0);
    end else if (ln == DEV) begin
      chk(gotCode == 2'd0, "R3", {tag, " code"}, gotCode, 0);
      chk(eCnt == 1, "R3", {tag, " count"}, eCnt, 1);
      chk(eOp[0] == 8'hC7 && eLen[0] == 1, "R3", {tag, " chip frame"}, {eOp[0], 8'(eLen[0])}, 16'hC701);
      chk(eOk[0], "R6", {tag, " gated"}, eOk[0], 1);
    end else begin
      n = ln / blk;
      chk(gotCode == 2'd0, "R4", {tag, " code"}, gotCode, 0);
      chk(eCnt == n, "R4", {tag, " count"}, eCnt, n);
      for (int k = 0; k < n && k < LOGN; k++) begin
        chk(eOp[k] == (sm ? 8'h20 : 8'hD8), "R5", {tag, " opcode"}, eOp[k], sm ? 8'h20 : 8'hD8);
        chk(eAdr[k] == 24'(st + k * blk) && eLen[k] == 4, "R4", {tag, " addr"}, eAdr[k], st + k * blk);
        chk(eOk[k], "R7", {tag, " poll+wren gating"}, eOk[k], 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csN && !txValid && !busy && !done, "R11", "reset state", {csN, txValid, busy, done}, 4'b1000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // small-block sweep, including out-of-range and chip-size cases
    for (int s = 0; s <= 8; s++)
      for (int n = 0; n <= 9 - s; n++) begin
        runErase(s * 4096, n * 4096, 1'b1, 0, -1, 1'b0);
        checkNormal(s * 4096, n * 4096, 1'b1, "small");
      end
    // misaligned lengths and unaligned start
    for (int n = 0; n < 3; n++) begin
      runErase(0, n * 4096 + 512, 1'b1, 0, -1, 1'b0);
      checkNormal(0, n * 4096 + 512, 1'b1, "R2 misaligned");
    end
    runErase(24'h000800, 2 * 4096, 1'b1, 0, -1, 1'b0);
    checkNormal(24'h000800, 2 * 4096, 1'b1, "unaligned start");
    // sector mode sweep
    for (int s = 0; s <= 2; s++)
      for (int n = 0; n <= 3 - s; n++) begin
        runErase(s * SECT, n * SECT, 1'b0, 0, -1, 1'b0);
        checkNormal(s * SECT, n * SECT, 1'b0, "sector");
      end
    runErase(0, 4096, 1'b0, 0, -1, 1'b0);
    checkNormal(0, 4096, 1'b0, "R2 small len in sector mode");
    // go while busy is ignored (R11)
    runErase(24'h001000, 3 * 4096, 1'b1, 2, -1, 1'b1);
    checkNormal(24'h001000, 3 * 4096, 1'b1, "R11 go while busy");
    // flash stuck busy after k erases (R8)
    for (int k = 0; k < 3; k++) begin
      runErase(24'h001000, 4 * 4096, 1'b1, 0, k, 1'b0);
      chk(gotCode == 2'd2, "R8", "stuck code", gotCode, 2);
      chk(gotAddr == 24'(24'h001000 + k * 4096), "R8", "stuck addr", gotAddr, 24'h001000 + k * 4096);
      chk(eCnt == k, "R8", "no erase after abort", eCnt, k);
    end
    // busy-length sweep across the timeout (R8, R6)
    begin
      bit seenTmo = 1'b0, seenOk = 1'b0;
      for (int b = 0; b <= 40; b++) begin
        runErase(0, 4096, 1'b1, b, -1, 1'b0);
        if (gotCode == 2'd0) begin
          seenOk = 1'b1;
          chk(!seenTmo, "R8", "success after a shorter timeout", b, 0);
          chk(eCnt == 1 && eOk[0] && eAdr[0] == 24'h0, "R6", "erase after long poll", eCnt, 1);
        end else begin
          seenTmo = 1'b1;
          chk(gotCode == 2'd2 && gotAddr == 24'h0, "R8", "timeout result", {gotCode, gotAddr}, {2'd2, 24'h0});
          chk(eCnt == 0, "R8", "no erase on timeout", eCnt, 0);
        end
      end
      chk(seenOk && seenTmo, "R8", "sweep spans timeout", {seenOk, seenTmo}, 2'b11);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule